// File: doc/BRIEF.md
# Programmable Pseudo-Floating-Point Coefficient Tap

This block is one reconfigurable tap of a multiplierless FIR filter. It scales a signed input sample by a coefficient that is loaded at run time as a packed word made of an exponent-like shift field and a normalized-value field. The coefficient has the value 2^-s multiplied by (1 + the sum of 2^-k over every set digit k), so the unshifted sample is always the leading operand. Each set digit of the normalized field adds a right-shifted copy of the sample. The copies are summed in a registered balanced adder tree that works on narrow operands, and the common shift is applied once, to the sum, in the output stage.

A coefficient is written with a single-cycle load strobe and stays in force until the next load. Samples are accepted whenever the input valid is high, one per cycle, and each result appears a fixed number of cycles later with its own valid. Every sample carries the coefficient that was in force when it was accepted, so a reload never disturbs results already in the pipeline. One reserved word, with the shift field at all ones and the normalized field at zero, stands for the coefficient zero. It is also the value the coefficient takes at reset.

Top module: `pfp_coef_tap`

## Requirements
- R1: With defaults (8-bit sample, 3-bit shift field in bits [10:8], 8-bit normalized field in bits [7:0] whose bit 7 is the digit of weight 2^-1 and bit 0 the digit of weight 2^-8), the product is floor(x * (256 + n) / 2^s), read as a signed 17-bit value with 8 fraction bits. Here x is the sample as a signed integer, n the normalized field as an unsigned integer and s the shift field.
- R2: Fraction bits below the output precision are dropped toward minus infinity, so a negative product rounds down, never toward zero.
- R3: The word with shift field 7 and normalized field 0 gives a product of exactly zero for every sample. Shift 7 with any nonzero normalized field is an ordinary coefficient.
- R4: A sample accepted at a rising edge yields its result at the sixth rising edge counting that edge as the first, i.e. ceil(log2(M+1)) + 2 edges, for every number of set digits.
- R5: outValid is high for exactly one cycle per accepted sample, in acceptance order, with one sample accepted on every cycle at full rate. While outValid is low, outProduct holds its last value.
- R6: A load takes effect on samples accepted after the load's edge. A sample accepted at the same edge as a load uses the previous coefficient.
- R7: A load while results are still in the pipeline does not change those results.
- R8: After reset, outValid is low, outProduct is zero and the coefficient is the zero word of R3, so samples sent before any load produce zero.
- R9: Full-scale samples with all digits set and shift 0 give exact results with no wrap: -128 gives -65408 and 127 gives 64897.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Synchronous reset, active low |
| coefLoad | input | 1 | Single-cycle strobe that writes coefWord |
| coefWord | input | SHIFT_W+NORM_W (11) | Packed coefficient, shift field above normalized field |
| inValid | input | 1 | Sample on inSample is accepted this cycle |
| inSample | input | DATA_W (8) | Signed input sample |
| outValid | output | 1 | outProduct carries a new result |
| outProduct | output | DATA_W+1+OUT_FRAC (17) | Signed product with OUT_FRAC fraction bits |

## Verification
The hardest situation to reach is a coefficient change racing the pipeline. Here a load and a sample share an edge, further samples follow back to back, and a second load lands while those results are still inside the adder tree. The stimulus drives exactly that sequence at full rate, so the old coefficient, the new one and a third all sit in the pipeline together. Each result is then checked against the coefficient that was in force when its sample was taken. Rounding on negative products and the reserved zero word are driven with sample and coefficient pairs chosen so that floor and truncation toward zero give different answers.

// File: rtl/pfp_tap_pkg.sv
package pfp_tap_pkg;

  // Strobes from the control to the datapath.
  typedef struct packed {
    logic capture;   // latch sample and current coefficient
    logic zeroCoef;  // current coefficient is the reserved zero word
    logic outLoad;   // last tree level holds a valid sum
  } tapStrobe_t;

endpackage

// File: rtl/pfp_tap_ctrl.sv
module pfp_tap_ctrl
  import pfp_tap_pkg::*;
#(
  parameter int SHIFT_W = 3,
  parameter int NORM_W  = 8,
  parameter int LAT     = 6,
  localparam int CW     = SHIFT_W + NORM_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          coefLoad,
  input  logic [CW-1:0] coefWord,
  input  logic          inValid,
  output logic [CW-1:0] coefQ,
  output tapStrobe_t    strobe,
  output logic          outValid
);

  localparam logic [CW-1:0] ZERO_WORD = {{SHIFT_W{1'b1}}, {NORM_W{1'b0}}};

  logic [LAT-1:0] validPipe;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      coefQ <= ZERO_WORD;
    end else if (coefLoad) begin
      coefQ <= coefWord;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validPipe <= '0;
    end else begin
      validPipe <= {validPipe[LAT-2:0], inValid};
    end
  end

  always_comb begin
    strobe.capture  = inValid;
    strobe.zeroCoef = (coefQ == ZERO_WORD);
    strobe.outLoad  = validPipe[LAT-2];
  end

  assign outValid = validPipe[LAT-1];

endmodule

// File: rtl/pfp_tap_datapath.sv
module pfp_tap_datapath
  import pfp_tap_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int SHIFT_W  = 3,
  parameter int NORM_W   = 8,
  parameter int OUT_FRAC = 8,
  localparam int CW      = SHIFT_W + NORM_W,
  localparam int SMAX    = (1 << SHIFT_W) - 1,
  localparam int TW      = DATA_W + 1 + NORM_W,
  localparam int WW      = TW + SMAX,
  localparam int OW      = DATA_W + 1 + OUT_FRAC,
  localparam int DROP    = NORM_W + SMAX - OUT_FRAC,
  localparam int NOPS    = NORM_W + 1,
  localparam int LEVELS  = $clog2(NOPS),
  localparam int NPAD    = 1 << LEVELS
) (
  input  logic              clk,
  input  logic              rstN,
  input  tapStrobe_t        strobe,
  input  logic [CW-1:0]     coefQ,
  input  logic [DATA_W-1:0] inSample,
  output logic [OW-1:0]     outProduct
);

  // Capture stage: sample and the coefficient in force travel together.
  logic [DATA_W-1:0]  xQ;
  logic [NORM_W-1:0]  normQ;
  logic [SHIFT_W-1:0] shiftQ;
  logic               zeroQ;

  always_ff @(posedge clk) begin
    if (strobe.capture) begin
      xQ     <= inSample;
      normQ  <= coefQ[NORM_W-1:0];
      shiftQ <= coefQ[CW-1 -: SHIFT_W];
      zeroQ  <= strobe.zeroCoef;
    end
  end

  // Operands: narrow, scaled by 2^NORM_W so no fraction bit is lost.
  logic signed [TW-1:0] xExt;
  logic signed [TW-1:0] ops [NPAD];

  assign xExt = {{(TW-DATA_W){xQ[DATA_W-1]}}, xQ};

  always_comb begin
    for (int k = 0; k < NPAD; k++) ops[k] = '0;
    ops[0] = zeroQ ? '0 : (xExt <<< NORM_W);
    for (int k = 1; k <= NORM_W; k++) begin
      if (normQ[NORM_W-k]) ops[k] = xExt <<< (NORM_W - k);
    end
  end

  // Balanced adder tree, one register per level; the shift rides along.
  for (genvar j = 1; j <= LEVELS; j++) begin : lvl
    localparam int N = NPAD >> j;
    logic signed [TW-1:0] node [N];
    logic [SHIFT_W-1:0]   sh;

    if (j == 1) begin : first
      always_ff @(posedge clk) begin
        for (int i = 0; i < N; i++) node[i] <= ops[2*i] + ops[2*i+1];
        sh <= shiftQ;
      end
    end else begin : inner
      always_ff @(posedge clk) begin
        for (int i = 0; i < N; i++) node[i] <= lvl[j-1].node[2*i] + lvl[j-1].node[2*i+1];
        sh <= lvl[j-1].sh;
      end
    end
  end

  // Output stage: single common right shift, then truncation toward -inf.
  logic signed [WW-1:0] wide;

  assign wide = {{SMAX{lvl[LEVELS].node[0][TW-1]}}, lvl[LEVELS].node[0]} <<< SMAX;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outProduct <= '0;
    end else if (strobe.outLoad) begin
      outProduct <= OW'(wide >>> (int'(lvl[LEVELS].sh) + DROP));
    end
  end

endmodule

// File: rtl/pfp_coef_tap.sv
module pfp_coef_tap
  import pfp_tap_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int SHIFT_W  = 3,
  parameter int NORM_W   = 8,
  parameter int OUT_FRAC = 8,
  localparam int CW      = SHIFT_W + NORM_W,
  localparam int OW      = DATA_W + 1 + OUT_FRAC,
  localparam int LAT     = $clog2(NORM_W + 1) + 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              coefLoad,
  input  logic [CW-1:0]     coefWord,
  input  logic              inValid,
  input  logic [DATA_W-1:0] inSample,
  output logic              outValid,
  output logic [OW-1:0]     outProduct
);

  tapStrobe_t    strobe;
  logic [CW-1:0] coefQ;

  pfp_tap_ctrl #(
    .SHIFT_W(SHIFT_W), .NORM_W(NORM_W), .LAT(LAT)
  ) ctrlI (
    .clk(clk), .rstN(rstN), .coefLoad(coefLoad), .coefWord(coefWord),
    .inValid(inValid), .coefQ(coefQ), .strobe(strobe), .outValid(outValid)
  );

  pfp_tap_datapath #(
    .DATA_W(DATA_W), .SHIFT_W(SHIFT_W), .NORM_W(NORM_W), .OUT_FRAC(OUT_FRAC)
  ) dpI (
    .clk(clk), .rstN(rstN), .strobe(strobe), .coefQ(coefQ),
    .inSample(inSample), .outProduct(outProduct)
  );

endmodule

// File: rtl/pfp_coef_tap_chk.sv
module pfp_coef_tap_chk #(
  parameter int DATA_W   = 8,
  parameter int SHIFT_W  = 3,
  parameter int NORM_W   = 8,
  parameter int OUT_FRAC = 8,
  localparam int CW      = SHIFT_W + NORM_W,
  localparam int OW      = DATA_W + 1 + OUT_FRAC,
  localparam int LAT     = $clog2(NORM_W + 1) + 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              coefLoad,
  input logic [CW-1:0]     coefWord,
  input logic              inValid,
  input logic [DATA_W-1:0] inSample,
  input logic              outValid,
  input logic [OW-1:0]     outProduct
);

  localparam logic [CW-1:0] ZERO_WORD = {{SHIFT_W{1'b1}}, {NORM_W{1'b0}}};

  logic [CW-1:0]  coefSeen;
  logic [LAT-1:0] acceptPipe;
  logic [LAT-1:0] zeroPipe;
  logic [LAT-1:0] negPipe;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      coefSeen   <= ZERO_WORD;
      acceptPipe <= '0;
      zeroPipe   <= '0;
      negPipe    <= '0;
    end else begin
      if (coefLoad) coefSeen <= coefWord;
      acceptPipe <= {acceptPipe[LAT-2:0], inValid};
      zeroPipe   <= {zeroPipe[LAT-2:0], inValid && (coefSeen == ZERO_WORD)};
      negPipe    <= {negPipe[LAT-2:0], inValid && inSample[DATA_W-1]};
    end
  end

  AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    outValid == acceptPipe[LAT-1]); // R4

  AST_ZERO_CODE: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && zeroPipe[LAT-1]) |-> (outProduct == '0)); // R3

  AST_SIGN_TRACKS: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !zeroPipe[LAT-1]) |-> (outProduct[OW-1] == negPipe[LAT-1])); // R1

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> $stable(outProduct)); // R5

endmodule

bind pfp_coef_tap pfp_coef_tap_chk #(
  .DATA_W(DATA_W), .SHIFT_W(SHIFT_W), .NORM_W(NORM_W), .OUT_FRAC(OUT_FRAC)
) chkI (
  .clk(clk), .rstN(rstN), .coefLoad(coefLoad), .coefWord(coefWord),
  .inValid(inValid), .inSample(inSample), .outValid(outValid), .outProduct(outProduct)
);

// File: tb/tb_pfp_coef_tap.sv
module tb_pfp_coef_tap;

  localparam int DATA_W   = 8;
  localparam int SHIFT_W  = 3;
  localparam int NORM_W   = 8;
  localparam int OUT_FRAC = 8;
  localparam int CW       = SHIFT_W + NORM_W;
  localparam int OW       = DATA_W + 1 + OUT_FRAC;
  localparam int SMAX     = (1 << SHIFT_W) - 1;
  localparam int LAT      = $clog2(NORM_W + 1) + 2;
  localparam logic [CW-1:0] ZERO_WORD = {{SHIFT_W{1'b1}}, {NORM_W{1'b0}}};

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              coefLoad = 1'b0;
  logic [CW-1:0]     coefWord = '0;
  logic              inValid = 1'b0;
  logic [DATA_W-1:0] inSample = '0;
  logic              outValid;
  logic [OW-1:0]     outProduct;

  always #4 clk = ~clk;

  pfp_coef_tap dut (
    .clk(clk), .rstN(rstN), .coefLoad(coefLoad), .coefWord(coefWord),
    .inValid(inValid), .inSample(inSample), .outValid(outValid), .outProduct(outProduct)
  );

  int    checks = 0;
  int    errors = 0;
  int    posCnt = 0;
  bit    done = 0;
  string curTag = "R1";

  typedef struct {
    longint expVal;
    int     cyc;
    string  tag;
  } pend_t;
  pend_t pending[$];
  logic [CW-1:0] modelCoef = ZERO_WORD;

  task automatic check(input bit ok, input string req, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic longint expected(input logic [CW-1:0] w, input logic [DATA_W-1:0] x);
    longint xs, nv, full;
    int s;
    if (w == ZERO_WORD) return 0;
    xs = longint'($signed(x));
    nv = longint'(1 << NORM_W) + longint'(w[NORM_W-1:0]);
    s  = int'(w[CW-1 -: SHIFT_W]);
    full = xs * nv * (longint'(1) << SMAX);
    return full >>> (s + NORM_W + SMAX - OUT_FRAC);
  endfunction

  // Reference model of the coefficient register and acceptance.
  always @(posedge clk) begin
    posCnt++;
    if (!rstN) begin
      modelCoef = ZERO_WORD;
      pending.delete();
    end else begin
      if (inValid) pending.push_back('{expected(modelCoef, inSample), posCnt, curTag});
      if (coefLoad) modelCoef = coefWord;
    end
  end

  // Output monitor, away from the active edge.
  always @(negedge clk) begin
    if (rstN && outValid) begin
      if (pending.size() == 0) begin
        check(1'b0, "R5 unexpected outValid", 1, 0);
      end else begin
        pend_t e;
        e = pending.pop_front();
        check(longint'($signed(outProduct)) == e.expVal, e.tag,
              longint'($signed(outProduct)), e.expVal);
        check(posCnt - e.cyc == LAT - 1, "R4 latency",
              longint'(posCnt - e.cyc + 1), longint'(LAT));
      end
    end
  end

  task automatic step(input bit ld, input logic [CW-1:0] w, input bit v, input logic [DATA_W-1:0] x);
    coefLoad = ld; coefWord = w; inValid = v; inSample = x;
    @(negedge clk);
    coefLoad = 1'b0; inValid = 1'b0;
  endtask

  task automatic drain();
    repeat (LAT + 2) @(negedge clk);
    check(pending.size() == 0, "R5 all results delivered", pending.size(), 0);
  endtask

  task automatic tReset();
    check(outValid == 1'b0, "R8 outValid after reset", outValid, 0);
    check(outProduct == '0, "R8 product after reset", longint'($signed(outProduct)), 0);
    curTag = "R8 reset coefficient is zero";
    step(0, '0, 1, 8'd100);
    step(0, '0, 1, 8'h80);
    drain();
  endtask

  task automatic tReference();
    curTag = "R1 reference coefficient";
    step(1, {3'd6, 8'h61}, 0, '0);
    step(0, '0, 1, 8'd100);
    step(0, '0, 1, 8'd127);
    step(0, '0, 1, 8'd1);
    step(0, '0, 1, 8'd0);
    step(1, {3'd2, 8'h5A}, 0, '0);
    step(0, '0, 1, 8'd77);
    step(0, '0, 1, 8'd33);
    drain();
  endtask

  task automatic tTruncation();
    curTag = "R2 floor on negative";
    step(1, {3'd7, 8'h01}, 0, '0);
    step(0, '0, 1, 8'hFF);    // -1 -> -3, not -2
    step(0, '0, 1, 8'd1);     //  1 ->  2
    step(0, '0, 1, 8'h9C);    // -100
    step(1, {3'd6, 8'h61}, 1, 8'h9C);
    step(0, '0, 1, 8'h9C);
    drain();
  endtask

  task automatic tDigitCounts();
    logic [NORM_W-1:0] pats [5] = '{8'h00, 8'h80, 8'h11, 8'hF0, 8'hFF};
    curTag = "R4 latency independent of digit count";
    for (int i = 0; i < 5; i++) begin
      step(1, {3'(i), pats[i]}, 0, '0);
      step(0, '0, 1, 8'd93);
      step(0, '0, 1, 8'hA5);
    end
    drain();
  endtask

  task automatic tZeroCode();
    curTag = "R3 zero word";
    step(1, ZERO_WORD, 0, '0);
    step(0, '0, 1, 8'd127);
    step(0, '0, 1, 8'h80);
    step(0, '0, 1, 8'd5);
    curTag = "R3 shift 7 nonzero digits";
    step(1, {3'd7, 8'h80}, 0, '0);
    step(0, '0, 1, 8'd127);
    step(0, '0, 1, 8'h80);
    drain();
  endtask

  task automatic tSwitch();
    curTag = "R6 load and sample same edge";
    step(1, {3'd1, 8'h40}, 0, '0);
    step(1, {3'd0, 8'hC3}, 1, 8'd50);   // old coefficient
    curTag = "R6 first sample after load";
    step(0, '0, 1, 8'd50);              // new coefficient
    curTag = "R7 load with results in flight";
    step(0, '0, 1, 8'hC8);
    step(1, {3'd5, 8'h0F}, 1, 8'd90);
    step(0, '0, 1, 8'd90);
    step(1, ZERO_WORD, 1, 8'd90);
    step(0, '0, 1, 8'd90);
    drain();
  endtask

  task automatic tExtremes();
    curTag = "R9 full scale";
    step(1, {3'd0, 8'hFF}, 0, '0);
    step(0, '0, 1, 8'h80);
    step(0, '0, 1, 8'h7F);
    drain();
    check(longint'($signed(outProduct)) == 64897, "R9 last product held",
          longint'($signed(outProduct)), 64897);
  endtask

  task automatic tIdleHold();
    logic [OW-1:0] held;
    held = outProduct;
    for (int i = 0; i < 4; i++) begin
      step(1, {3'd3, 8'h33}, 0, '0);
      check(outValid == 1'b0, "R5 no valid while idle", outValid, 0);
      check(outProduct == held, "R5 product holds while idle",
            longint'($signed(outProduct)), longint'($signed(held)));
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tReference();
    tTruncation();
    tDigitCounts();
    tZeroCode();
    tSwitch();
    tExtremes();
    tIdleHold();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule